// File: doc/BRIEF.md
# Dual-Clock Flagged FIFO

This block is a first-in, first-out buffer whose write port and read port run on unrelated clocks. Words enter on the write clock while the active-low write enable is low and the buffer is not full. They leave in the same order on the read clock while the active-low read enable is low and the buffer is not empty. Each accepted read loads the word into a registered output, which keeps its value until the next accepted read.

Five active-low flags report how full the buffer is. The read domain drives empty and almost-empty. The write domain drives half-full, almost-full and full. The two pointers cross between the domains as Gray code through a register chain, two stages by default. Because of that chain, a flag that reports the other side's progress clears only after two edges of its own clock. A flag that reports its own side's action changes at once. The almost-empty threshold n and the almost-full threshold m are taken while reset is held: from the offset inputs when the select input is high, and from parameter defaults when it is low.

Top module: `dcfifo_flags`

## Requirements
- R1: Words are delivered on the read side in the order in which they were accepted on the write side. A write is accepted on a rising write-clock edge only while `wr_en_n` is 0 and `full_n` is 1.
- R2: `rd_data` is 0 after reset. It loads the head word on the rising read-clock edge that accepts a read (`rd_en_n` = 0 and `empty_n` = 1). Otherwise it holds its value.
- R3: `empty_n` is 0 exactly when the read side sees no stored word. It falls on the read edge that takes the last word. After a write into an empty buffer, it rises on the second rising read-clock edge after the write edge.
- R4: `ae_n` is 1 exactly when the stored count seen by the read side is greater than n, that is, when n+1 or more words are stored.
- R5: `hf_n` is 0 exactly when the stored count seen by the write side is at least D/2+1, where D = 2^AW.
- R6: `af_n` is 0 exactly when the stored count seen by the write side is at least D−m.
- R7: `full_n` falls on the write edge that stores the D-th word. A write attempted while full is dropped: the buffer content and the order of the words do not change.
- R8: When the buffer is full, the first read makes `full_n` rise on the second rising write-clock edge after the read edge.
- R9: A read attempted while `empty_n` is 0 is ignored. `rd_data` holds its value, and the next word written is the next word read.
- R10: While `rst_n` is 0, each domain captures its offset on its clock edges. With `cfg_sel` = 1 it takes n from `cfg_ae_ofs` and m from `cfg_af_ofs`. With `cfg_sel` = 0 it takes the parameters `DFLT_AE` and `DFLT_AF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both domains; hold it for several edges of each clock |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DW | Word to store |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DW | Registered read word |
| cfg_sel | input | 1 | During reset: 1 takes the offset inputs, 0 takes the defaults |
| cfg_ae_ofs | input | AW | Almost-empty offset n, sampled during reset |
| cfg_af_ofs | input | AW | Almost-full offset m, sampled during reset |
| empty_n | output | 1 | Low when empty (read domain) |
| ae_n | output | 1 | Low while n or fewer words are stored (read domain) |
| hf_n | output | 1 | Low while D/2+1 or more words are stored (write domain) |
| af_n | output | 1 | Low while D−m or more words are stored (write domain) |
| full_n | output | 1 | Low when D words are stored (write domain) |

## Verification
The bench builds the block with AW = 4 and DW = 8, which gives a depth of 16, a half-full point of 9, and defaults n = 3 and m = 5. With that depth the bench can step through every fill level from 0 to 16 and back down again, comparing all five flags with values computed arithmetically at each level. It does this once with the default offsets and once with offsets loaded through the ports (n = 5, m = 2). The two clocks have periods of 4 ns and 6 ns and their rising edges never coincide. This makes the two-edge latencies of the empty and full flags exact to count, and the overflow and underflow attempts can be seen at the data output.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   // Binary to reflected Gray code.
   function automatic logic [31:0] gray_of(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   // Reflected Gray code back to binary.
   function automatic logic [31:0] bin_of(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("dcf_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= '0;
         else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DW = 18,
   parameter int AW = 10
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int D = 1 << AW;

   logic [DW-1:0] mem [D];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside #(
   parameter int AW      = 10,
   parameter int DFLT_AF = 127,
   parameter int STAGES  = 2
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic          cfg_sel,
   input  logic [AW-1:0] cfg_af_ofs,
   input  logic [AW:0]   rptr_g_x,
   output logic          wr_go,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wptr_g,
   output logic          full_n,
   output logic          hf_n,
   output logic          af_n
);
   localparam int          D       = 1 << AW;
   localparam logic [AW:0] DEPTH_V = (AW+1)'(D);
   localparam logic [AW:0] HALF_V  = (AW+1)'(D/2 + 1);

   logic [AW:0]   wptr_b, wptr_nx, rsync_g, rsync_b, fill, af_lim;
   logic [AW-1:0] af_ofs;

   dcf_sync #(.W(AW+1), .STAGES(STAGES)) u_rsync (
      .clk(wr_clk), .rst_n(rst_n), .d(rptr_g_x), .q(rsync_g)
   );

   assign rsync_b = (AW+1)'(dcf_pkg::bin_of(32'(rsync_g)));
   assign fill    = wptr_b - rsync_b;
   assign wptr_nx = wptr_b + 1'b1;
   assign wr_go   = !wr_en_n && full_n;
   assign waddr   = wptr_b[AW-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_b <= '0;
         wptr_g <= '0;
      end else if (wr_go) begin
         wptr_b <= wptr_nx;
         wptr_g <= (AW+1)'(dcf_pkg::gray_of(32'(wptr_nx)));
      end
   end

   // offset taken on clock edges while reset is held
   always_ff @(posedge wr_clk) begin
      if (!rst_n) af_ofs <= cfg_sel ? cfg_af_ofs : AW'(DFLT_AF);
   end

   assign af_lim = DEPTH_V - {1'b0, af_ofs};
   assign full_n = (fill != DEPTH_V);
   assign hf_n   = !(fill >= HALF_V);
   assign af_n   = !(fill >= af_lim);
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside #(
   parameter int AW      = 10,
   parameter int DFLT_AE = 127,
   parameter int STAGES  = 2
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en_n,
   input  logic          cfg_sel,
   input  logic [AW-1:0] cfg_ae_ofs,
   input  logic [AW:0]   wptr_g_x,
   output logic          rd_go,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rptr_g,
   output logic          empty_n,
   output logic          ae_n
);
   logic [AW:0]   rptr_b, rptr_nx, wsync_g, wsync_b, avail;
   logic [AW-1:0] ae_ofs;

   dcf_sync #(.W(AW+1), .STAGES(STAGES)) u_wsync (
      .clk(rd_clk), .rst_n(rst_n), .d(wptr_g_x), .q(wsync_g)
   );

   assign wsync_b = (AW+1)'(dcf_pkg::bin_of(32'(wsync_g)));
   assign avail   = wsync_b - rptr_b;
   assign rptr_nx = rptr_b + 1'b1;
   assign rd_go   = !rd_en_n && empty_n;
   assign raddr   = rptr_b[AW-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_b <= '0;
         rptr_g <= '0;
      end else if (rd_go) begin
         rptr_b <= rptr_nx;
         rptr_g <= (AW+1)'(dcf_pkg::gray_of(32'(rptr_nx)));
      end
   end

   always_ff @(posedge rd_clk) begin
      if (!rst_n) ae_ofs <= cfg_sel ? cfg_ae_ofs : AW'(DFLT_AE);
   end

   assign empty_n = (avail != '0);
   assign ae_n    = (avail > {1'b0, ae_ofs});
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
   parameter int DW          = 18,
   parameter int AW          = 10,
   parameter int DFLT_AE     = 127,
   parameter int DFLT_AF     = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en_n,
   output logic [DW-1:0] rd_data,
   input  logic          cfg_sel,
   input  logic [AW-1:0] cfg_ae_ofs,
   input  logic [AW-1:0] cfg_af_ofs,
   output logic          empty_n,
   output logic          ae_n,
   output logic          hf_n,
   output logic          af_n,
   output logic          full_n
);
   localparam int D = 1 << AW;

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("dcfifo_flags: AW out of range 2..16");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dcfifo_flags: DW must be positive");
   end
   if (DFLT_AE < 0 || DFLT_AE >= D || DFLT_AF < 0 || DFLT_AF >= D) begin : g_bad_ofs
      $error("dcfifo_flags: default offsets must lie in 0..D-1");
   end

   logic          wr_go, rd_go;
   logic [AW-1:0] waddr, raddr;
   logic [AW:0]   wptr_g, rptr_g;

   dcf_wside #(.AW(AW), .DFLT_AF(DFLT_AF), .STAGES(SYNC_STAGES)) u_wside (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .cfg_sel(cfg_sel),
      .cfg_af_ofs(cfg_af_ofs), .rptr_g_x(rptr_g), .wr_go(wr_go), .waddr(waddr),
      .wptr_g(wptr_g), .full_n(full_n), .hf_n(hf_n), .af_n(af_n)
   );

   dcf_rside #(.AW(AW), .DFLT_AE(DFLT_AE), .STAGES(SYNC_STAGES)) u_rside (
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .cfg_sel(cfg_sel),
      .cfg_ae_ofs(cfg_ae_ofs), .wptr_g_x(wptr_g), .rd_go(rd_go), .raddr(raddr),
      .rptr_g(rptr_g), .empty_n(empty_n), .ae_n(ae_n)
   );

   dcf_ram #(.DW(DW), .AW(AW)) u_ram (
      .wr_clk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
      .rd_clk(rd_clk), .rst_n(rst_n), .re(rd_go), .raddr(raddr), .rdata(rd_data)
   );
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
   parameter int DW = 18,
   parameter int AW = 10
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wr_en_n,
   input logic          rd_en_n,
   input logic [DW-1:0] rd_data,
   input logic          empty_n,
   input logic          ae_n,
   input logic          hf_n,
   input logic          af_n,
   input logic          full_n,
   input logic [AW:0]   wptr_g,
   input logic [AW:0]   rptr_g
);
   // R1
   wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wptr_g != $past(wptr_g)) |-> ($countones(wptr_g ^ $past(wptr_g)) == 1));

   // R2
   rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rptr_g != $past(rptr_g)) |-> ($countones(rptr_g ^ $past(rptr_g)) == 1));

   // R2
   rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_en_n |=> $stable(rd_data));

   // R7
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n && !wr_en_n) |=> $stable(wptr_g));

   // R9
   no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && !rd_en_n) |=> ($stable(rptr_g) && $stable(rd_data)));

   // R5
   full_implies_half_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> (!hf_n && !af_n));

   // R4
   empty_implies_low_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !ae_n);
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DW(DW), .AW(AW)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
   .rd_en_n(rd_en_n), .rd_data(rd_data), .empty_n(empty_n), .ae_n(ae_n),
   .hf_n(hf_n), .af_n(af_n), .full_n(full_n), .wptr_g(wptr_g), .rptr_g(rptr_g)
);

// File: tb/dcfifo_flags_tb.sv
`timescale 1ns/1ps
module dcfifo_flags_tb;
   localparam int DW = 8;
   localparam int AW = 4;
   localparam int D  = 1 << AW;
   localparam int HALF = D/2 + 1;
   localparam int DFLT_AE = 3;
   localparam int DFLT_AF = 5;

   logic wr_clk = 0, rd_clk = 0, rst_n = 0;
   logic wr_en_n = 1, rd_en_n = 1, cfg_sel = 0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] cfg_ae_ofs = '0, cfg_af_ofs = '0;
   logic [DW-1:0] rd_data;
   logic empty_n, ae_n, hf_n, af_n, full_n;
   int nchk = 0, nerr = 0;

   dcfifo_flags #(.DW(DW), .AW(AW), .DFLT_AE(DFLT_AE), .DFLT_AF(DFLT_AF)) u_dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
      .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_data(rd_data), .cfg_sel(cfg_sel),
      .cfg_ae_ofs(cfg_ae_ofs), .cfg_af_ofs(cfg_af_ofs), .empty_n(empty_n),
      .ae_n(ae_n), .hf_n(hf_n), .af_n(af_n), .full_n(full_n)
   );

   // 250 MHz write clock, rising edges at even ns; read clock rises at odd ns
   always #2 wr_clk = ~wr_clk;
   initial forever #3 rd_clk = ~rd_clk;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] val(input int k);
      return DW'((k * 7 + 1) & 255);
   endfunction

   task automatic do_reset(input logic sel, input int n, input int m);
      rst_n = 0;
      cfg_sel = sel;
      cfg_ae_ofs = AW'(n);
      cfg_af_ofs = AW'(m);
      repeat (4) @(posedge wr_clk);
      repeat (4) @(posedge rd_clk);
      @(negedge wr_clk);
      rst_n = 1;
      cfg_sel = 0;
      cfg_ae_ofs = '0;
      cfg_af_ofs = '0;
      #60;
   endtask

   task automatic write_word(input logic [DW-1:0] v);
      @(negedge wr_clk);
      wr_en_n = 0;
      wr_data = v;
      @(negedge wr_clk);
      wr_en_n = 1;
   endtask

   task automatic read_word();
      @(negedge rd_clk);
      rd_en_n = 0;
      @(negedge rd_clk);
      rd_en_n = 1;
   endtask

   task automatic check_flags(input int c, input int n, input int m, input string sfx);
      chk("R3", int'(empty_n), int'(c != 0));
      chk({"R4", sfx}, int'(ae_n), int'(c > n));
      chk("R5", int'(hf_n), int'(!(c >= HALF)));
      chk({"R6", sfx}, int'(af_n), int'(!(c >= D - m)));
      chk("R7", int'(full_n), int'(c < D));
   endtask

   task automatic fill_sweep(input int n, input int m, input string sfx);
      for (int k = 1; k <= D; k++) begin
         write_word(val(k));
         if (k == D) chk("R7 immediate", int'(full_n), 0);
         #60;
         check_flags(k, n, m, sfx);
      end
   endtask

   task automatic drain_sweep(input int n, input int m, input string sfx);
      for (int k = 1; k <= D; k++) begin
         read_word();
         chk("R1 order", int'(rd_data), int'(val(k)));
         if (k == D) chk("R3 immediate", int'(empty_n), 0);
         #60;
         check_flags(D - k, n, m, sfx);
      end
   endtask

   initial begin
      #400000;
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      // defaults: n = 3, m = 5 (R10)
      do_reset(1'b0, 9, 9);
      chk("R2 reset", int'(rd_data), 0);
      check_flags(0, DFLT_AE, DFLT_AF, " R10");
      fill_sweep(DFLT_AE, DFLT_AF, " R10");

      // write while full is dropped (R7)
      write_word(8'hEE);
      #60;
      chk("R7 blocked", int'(full_n), 0);
      drain_sweep(DFLT_AE, DFLT_AF, " R10");

      // read while empty is ignored (R9)
      read_word();
      chk("R9 hold", int'(rd_data), int'(val(D)));
      #60;
      write_word(8'h5A);
      #60;
      read_word();
      chk("R9 next", int'(rd_data), 32'h5A);
      #60;

      // empty deasserts on the second read edge (R3)
      @(negedge wr_clk);
      wr_en_n = 0;
      wr_data = 8'hC3;
      @(posedge wr_clk);
      #0.5 wr_en_n = 1;
      @(posedge rd_clk);
      #0.5 chk("R3 after edge 1", int'(empty_n), 0);
      @(posedge rd_clk);
      #0.5 chk("R3 after edge 2", int'(empty_n), 1);
      read_word();
      chk("R2 load", int'(rd_data), 32'hC3);
      #60;

      // full deasserts on the second write edge (R8)
      for (int k = 1; k <= D; k++) write_word(val(k));
      #60;
      chk("R8 full", int'(full_n), 0);
      @(negedge rd_clk);
      rd_en_n = 0;
      @(posedge rd_clk);
      #0.5 rd_en_n = 1;
      @(posedge wr_clk);
      #0.5 chk("R8 after edge 1", int'(full_n), 0);
      @(posedge wr_clk);
      #0.5 chk("R8 after edge 2", int'(full_n), 1);
      chk("R2 first", int'(rd_data), int'(val(1)));
      for (int k = 2; k <= D; k++) read_word();
      chk("R1 last", int'(rd_data), int'(val(D)));
      #60;
      check_flags(0, DFLT_AE, DFLT_AF, "");

      // offsets loaded from the ports: n = 5, m = 2 (R10)
      do_reset(1'b1, 5, 2);
      chk("R2 reset", int'(rd_data), 0);
      fill_sweep(5, 2, " R10");
      drain_sweep(5, 2, " R10");

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule